// File: doc/BRIEF.md
# Four-Way Write-Back Cache Tag Controller

This block holds the tag, valid, dirty and replacement state of a 16 KB unified cache that has four ways of 256 sets and 16-byte lines. It does not store data. It takes one processor read or write per cycle and answers one cycle later. The answer gives hit or miss and the way involved. It also raises any line-fill request, the write-back of a displaced modified line with a mask of its modified doublewords, and any write that must go out to the bus.

Two global mode inputs set the behaviour. The write-policy input selects write-back or write-through. The cache-disable input stops new allocation, but lookups, hits and dirty marking continue. A flush command walks the whole array one entry per cycle. It writes back every modified line and leaves the cache empty, so that with cache-disable set the cache is fully off.

Top module: `wbc_tag_ctrl`

## Requirements
- R1: While rst_n is low, and after its release, every entry is invalid and clean, every PLRU field is 000, and all outputs are 0.
- R2: A request is a hit when a valid way of set addr[11:4] holds tag addr[31:12]. One cycle after an accepted request, rsp_hit or rsp_miss pulses for exactly one cycle. On a hit, rsp_way gives the matching way.
- R3: When cache-disable is 0, a read miss allocates one way. The way is the lowest-numbered invalid way of the set, or the PLRU victim when all four ways are valid. fill_req pulses with fill_addr = {addr[31:4],4'h0}, and rsp_way gives the allocated way. The new entry is valid and clean.
- R4: PLRU field p[2:0] of each set: p[0]=0 points to ways {0,1} and 1 to ways {2,3}. p[1] picks way 0 (0) or way 1 (1). p[2] picks way 2 (0) or way 3 (1). Every hit and every fill sets the bits along the used way's path so that they point away from it.
- R5: A write hit in write-back mode (mode_wb=1) that is not locked and has a nonzero req_be sets dirty bit addr[3:2] of that entry and issues no bus write. Dirty bit i covers bytes 4i..4i+3 of the line.
- R6: A write issues bus_wr_req, with bus_wr_addr = req_addr and bus_wr_be = req_be, in three cases: it misses, mode_wb=0, or req_lock=1. Such a write sets no dirty bit. A write miss never allocates.
- R7: A fill into a valid way with any dirty bit set pulses wb_req in the same cycle as fill_req. wb_addr = {old tag, set, 4'h0} and wb_mask = the old dirty bits. A clean victim causes no write-back.
- R8: With mode_cd=1, a read miss gives rsp_miss with no fill and no state change. Hits, PLRU updates and dirty marking still occur.
- R9: flush_req while idle raises busy for 1024 cycles. The walk visits set 0 ways 0..3, then set 1, and so on. For each valid entry with a nonzero dirty mask it pulses wb_req with that entry's address and mask one cycle later. It clears every entry and PLRU field. Requests are ignored while busy is high and in the cycle flush_req is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lock | input | 1 | Locked access |
| req_addr | input | 32 | Physical address |
| req_be | input | 4 | Byte enables within the addressed doubleword |
| mode_cd | input | 1 | Cache disable: no new fills |
| mode_wb | input | 1 | 1 = write-back, 0 = write-through |
| flush_req | input | 1 | Start write-back-and-invalidate walk |
| busy | output | 1 | Flush walk in progress |
| rsp_hit | output | 1 | Previous request hit |
| rsp_miss | output | 1 | Previous request missed |
| rsp_way | output | 2 | Hit way or allocated way |
| fill_req | output | 1 | Line fill request |
| fill_addr | output | 32 | Line address to fill |
| wb_req | output | 1 | Write-back of a modified line |
| wb_addr | output | 32 | Line address written back |
| wb_mask | output | 4 | Modified doublewords of that line |
| bus_wr_req | output | 1 | Write to be issued on the bus |
| bus_wr_addr | output | 32 | Address of that write |
| bus_wr_be | output | 4 | Byte enables of that write |

## Verification
Two pairs of events can land in the same cycle, and the bench provokes both. The first pair is a line fill and a write-back: the bench fills all four ways of a set, dirties each of them, then misses, so the fill and the eviction of the chosen victim appear in one response. The second pair is a flush command and a request: both are raised together, and the bench expects the request to produce no response and the walk to start. A behavioural model runs beside the design, and every output is compared on every cycle. This covers directed sequences and a long stretch of random traffic with changing modes and occasional flushes.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef logic [WAY_W-1:0] way_t;
  typedef logic [WAYS-2:0]  plru_t;

  // Tree walk: bit 0 chooses the pair, bit 1 / bit 2 the way inside it.
  function automatic way_t plru_victim(plru_t p);
    if (!p[0]) return {1'b0, p[1]};
    else       return {1'b1, p[2]};
  endfunction

  // Point every node on the used way's path away from that way.
  function automatic plru_t plru_touch(plru_t p, way_t w);
    plru_t r;
    r = p;
    if (!w[1]) begin
      r[0] = 1'b1;
      r[1] = ~w[0];
    end else begin
      r[0] = 1'b0;
      r[2] = ~w[0];
    end
    return r;
  endfunction
endpackage

// File: rtl/wbc_lookup.sv
module wbc_lookup
  import wbc_pkg::*;
#(
  parameter int TAG_W = 20
) (
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0]            way_vld,
  input  logic [TAG_W-1:0]           req_tag,
  output logic                       hit,
  output way_t                       hit_way
);
  logic [WAYS-1:0] match;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = way_vld[w] && (way_tag[w] == req_tag);
    end
  endgenerate

  always_comb begin
    hit     = |match;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = way_t'(w);
    end
  end
endmodule

// File: rtl/wbc_victim.sv
module wbc_victim
  import wbc_pkg::*;
(
  input  logic [WAYS-1:0] way_vld,
  input  plru_t           plru,
  output way_t            victim
);
  logic any_free;
  way_t free_way;

  always_comb begin
    any_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_vld[w]) begin
        any_free = 1'b1;
        free_way = way_t'(w);
      end
    end
    victim = any_free ? free_way : plru_victim(plru);
  end
endmodule

// File: rtl/wbc_flush_walk.sv
module wbc_flush_walk #(
  parameter int SET_W = 8,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [SET_W-1:0] cur_set,
  output logic [WAY_W-1:0] cur_way
);
  localparam int PTR_W = SET_W + WAY_W;

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             busy_q, busy_d;

  always_comb begin
    ptr_d  = ptr_q;
    busy_d = busy_q;
    if (busy_q) begin
      ptr_d = ptr_q + 1'b1;
      if (&ptr_q) busy_d = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      ptr_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q || start) begin
      ptr_q  <= ptr_d;
      busy_q <= busy_d;
    end
  end

  assign busy    = busy_q;
  assign cur_way = ptr_q[WAY_W-1:0];
  assign cur_set = ptr_q[PTR_W-1:WAY_W];
endmodule

// File: rtl/wbc_tag_ctrl.sv
module wbc_tag_ctrl
  import wbc_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int SET_W  = 8,
  parameter  int OFF_W  = 4,
  localparam int NDW    = 1 << (OFF_W - 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_lock,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic              mode_cd,
  input  logic              mode_wb,
  input  logic              flush_req,
  output logic              busy,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [1:0]        rsp_way,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [NDW-1:0]    wb_mask,
  output logic              bus_wr_req,
  output logic [ADDR_W-1:0] bus_wr_addr,
  output logic [3:0]        bus_wr_be
);
  localparam int SETS  = 1 << SET_W;
  localparam int TAG_W = ADDR_W - SET_W - OFF_W;
  localparam int DWI_W = OFF_W - 2;

  // request fields
  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] req_tag;
  logic [DWI_W-1:0] dw_idx;

  assign set_idx = req_addr[OFF_W +: SET_W];
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign dw_idx  = req_addr[OFF_W-1:2];

  // state arrays
  logic [TAG_W-1:0] tag_q [WAYS][SETS];
  logic [SETS-1:0]  vld_q [WAYS];
  logic [NDW-1:0]   dty_q [WAYS][SETS];
  plru_t            lru_q [SETS];

  logic [WAYS-1:0][TAG_W-1:0] cur_tag;
  logic [WAYS-1:0]            cur_vld;
  logic [WAYS-1:0][NDW-1:0]   cur_dty;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_rd
      assign cur_tag[w] = tag_q[w][set_idx];
      assign cur_vld[w] = vld_q[w][set_idx];
      assign cur_dty[w] = dty_q[w][set_idx];
    end
  endgenerate

  logic hit;
  way_t hit_way, victim;

  wbc_lookup #(.TAG_W(TAG_W)) u_lookup (
    .way_tag (cur_tag),
    .way_vld (cur_vld),
    .req_tag (req_tag),
    .hit     (hit),
    .hit_way (hit_way)
  );

  wbc_victim u_victim (
    .way_vld (cur_vld),
    .plru    (lru_q[set_idx]),
    .victim  (victim)
  );

  logic             fl_busy;
  logic [SET_W-1:0] fl_set;
  way_t             fl_way;

  wbc_flush_walk #(.SET_W(SET_W), .WAY_W(WAY_W)) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (flush_req),
    .busy    (fl_busy),
    .cur_set (fl_set),
    .cur_way (fl_way)
  );

  // control decisions
  logic  acc, do_hit, do_fill, set_dirty, bus_wr, evict_wb, lru_upd, flush_wb;
  plru_t lru_new;

  always_comb begin
    acc       = req_valid && !fl_busy && !flush_req;
    do_hit    = acc && hit;
    do_fill   = acc && !hit && !req_write && !mode_cd;
    set_dirty = do_hit && req_write && mode_wb && !req_lock && (|req_be);
    bus_wr    = acc && req_write && (!mode_wb || req_lock || !hit);
    evict_wb  = do_fill && cur_vld[victim] && (|cur_dty[victim]);
    lru_upd   = do_hit || do_fill;
    lru_new   = plru_touch(lru_q[set_idx], do_hit ? hit_way : victim);
    flush_wb  = fl_busy && vld_q[fl_way][fl_set] && (|dty_q[fl_way][fl_set]);
  end

  // tag storage: no reset, written only on allocation
  always_ff @(posedge clk) begin
    if (do_fill) tag_q[victim][set_idx] <= req_tag;
  end

  // valid, dirty and replacement state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) begin
        vld_q[w] <= '0;
        for (int s = 0; s < SETS; s++) dty_q[w][s] <= '0;
      end
      for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
    end else if (fl_busy) begin
      vld_q[fl_way][fl_set] <= 1'b0;
      dty_q[fl_way][fl_set] <= '0;
      if (fl_way == way_t'(WAYS - 1)) lru_q[fl_set] <= '0;
    end else begin
      if (do_fill) begin
        vld_q[victim][set_idx] <= 1'b1;
        dty_q[victim][set_idx] <= '0;
      end
      if (set_dirty) dty_q[hit_way][set_idx][dw_idx] <= 1'b1;
      if (lru_upd)   lru_q[set_idx] <= lru_new;
    end
  end

  // response next state
  logic              hit_d, miss_d, fill_d, wb_d, bw_d;
  way_t              way_d;
  logic [ADDR_W-1:0] fill_addr_d, wb_addr_d, bw_addr_d;
  logic [NDW-1:0]    wb_mask_d;
  logic [3:0]        bw_be_d;

  always_comb begin
    hit_d       = do_hit;
    miss_d      = acc && !hit;
    way_d       = do_hit ? hit_way : (do_fill ? victim : '0);
    fill_d      = do_fill;
    fill_addr_d = do_fill ? {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} : '0;
    wb_d        = evict_wb || flush_wb;
    wb_addr_d   = '0;
    wb_mask_d   = '0;
    if (evict_wb) begin
      wb_addr_d = {cur_tag[victim], set_idx, {OFF_W{1'b0}}};
      wb_mask_d = cur_dty[victim];
    end else if (flush_wb) begin
      wb_addr_d = {tag_q[fl_way][fl_set], fl_set, {OFF_W{1'b0}}};
      wb_mask_d = dty_q[fl_way][fl_set];
    end
    bw_d      = bus_wr;
    bw_addr_d = bus_wr ? req_addr : '0;
    bw_be_d   = bus_wr ? req_be : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit     <= 1'b0;
      rsp_miss    <= 1'b0;
      rsp_way     <= '0;
      fill_req    <= 1'b0;
      fill_addr   <= '0;
      wb_req      <= 1'b0;
      wb_addr     <= '0;
      wb_mask     <= '0;
      bus_wr_req  <= 1'b0;
      bus_wr_addr <= '0;
      bus_wr_be   <= '0;
    end else begin
      rsp_hit     <= hit_d;
      rsp_miss    <= miss_d;
      rsp_way     <= way_d;
      fill_req    <= fill_d;
      fill_addr   <= fill_addr_d;
      wb_req      <= wb_d;
      wb_addr     <= wb_addr_d;
      wb_mask     <= wb_mask_d;
      bus_wr_req  <= bw_d;
      bus_wr_addr <= bw_addr_d;
      bus_wr_be   <= bw_be_d;
    end
  end

  assign busy = fl_busy;
endmodule

// File: rtl/wbc_tag_ctrl_chk.sv
module wbc_tag_ctrl_chk #(
  parameter int NDW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           flush_req,
  input logic           mode_cd,
  input logic           busy,
  input logic           rsp_hit,
  input logic           rsp_miss,
  input logic           fill_req,
  input logic           wb_req,
  input logic [NDW-1:0] wb_mask,
  input logic           bus_wr_req
);
  // R2
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_miss));

  // R3
  fill_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> rsp_miss);

  // R6
  write_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_req |-> !fill_req);

  // R7
  wb_mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> (wb_mask != '0));

  // R8
  cd_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_cd |=> !fill_req);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(flush_req));

  // R9
  busy_ignores_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !(rsp_hit || rsp_miss || fill_req || bus_wr_req));
endmodule

bind wbc_tag_ctrl wbc_tag_ctrl_chk #(.NDW(NDW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush_req  (flush_req),
  .mode_cd    (mode_cd),
  .busy       (busy),
  .rsp_hit    (rsp_hit),
  .rsp_miss   (rsp_miss),
  .fill_req   (fill_req),
  .wb_req     (wb_req),
  .wb_mask    (wb_mask),
  .bus_wr_req (bus_wr_req)
);

// File: tb/tb_wbc_tag_ctrl.sv
module tb_wbc_tag_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        req_valid, req_write, req_lock, mode_cd, mode_wb, flush_req;
  logic [31:0] req_addr;
  logic [3:0]  req_be;
  logic        busy, rsp_hit, rsp_miss, fill_req, wb_req, bus_wr_req;
  logic [1:0]  rsp_way;
  logic [31:0] fill_addr, wb_addr, bus_wr_addr;
  logic [3:0]  wb_mask, bus_wr_be;

  wbc_tag_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_lock(req_lock), .req_addr(req_addr), .req_be(req_be),
    .mode_cd(mode_cd), .mode_wb(mode_wb), .flush_req(flush_req),
    .busy(busy), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_way(rsp_way),
    .fill_req(fill_req), .fill_addr(fill_addr), .wb_req(wb_req),
    .wb_addr(wb_addr), .wb_mask(wb_mask), .bus_wr_req(bus_wr_req),
    .bus_wr_addr(bus_wr_addr), .bus_wr_be(bus_wr_be)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bit running = 0;

  // ---------------- reference model ----------------
  bit [19:0] m_tag [4][256];
  bit        m_v   [4][256];
  bit [3:0]  m_d   [4][256];
  bit [2:0]  m_lru [256];
  bit        m_busy;
  int        m_ptr;

  bit        e_busy, e_hit, e_miss, e_fill, e_wb, e_bw;
  bit [1:0]  e_way;
  bit [31:0] e_fill_addr, e_wb_addr, e_bw_addr;
  bit [3:0]  e_wb_mask, e_bw_be;

  function automatic int pick_victim(int s);
    for (int w = 0; w < 4; w++) if (!m_v[w][s]) return w;
    if (m_lru[s][0] == 1'b0) return m_lru[s][1] ? 1 : 0;
    return m_lru[s][2] ? 3 : 2;
  endfunction

  task automatic touch(int s, int w);
    case (w)
      0: begin m_lru[s][0] = 1; m_lru[s][1] = 1; end
      1: begin m_lru[s][0] = 1; m_lru[s][1] = 0; end
      2: begin m_lru[s][0] = 0; m_lru[s][2] = 1; end
      default: begin m_lru[s][0] = 0; m_lru[s][2] = 0; end
    endcase
  endtask

  always @(posedge clk) begin
    int s, w, hw, v;
    bit [19:0] t;
    e_hit = 0; e_miss = 0; e_fill = 0; e_wb = 0; e_bw = 0; e_way = 0;
    e_fill_addr = 0; e_wb_addr = 0; e_wb_mask = 0; e_bw_addr = 0; e_bw_be = 0;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 256; j++) begin m_v[i][j] = 0; m_d[i][j] = 0; end
      for (int j = 0; j < 256; j++) m_lru[j] = 0;
      m_busy = 0; m_ptr = 0;
    end else begin
      if (m_busy) begin
        s = m_ptr / 4; w = m_ptr % 4;
        if (m_v[w][s] && m_d[w][s] != 0) begin
          e_wb = 1; e_wb_addr = {m_tag[w][s], s[7:0], 4'h0}; e_wb_mask = m_d[w][s];
        end
        m_v[w][s] = 0; m_d[w][s] = 0;
        if (w == 3) m_lru[s] = 0;
        m_ptr++;
        if (m_ptr == 1024) m_busy = 0;
      end else if (flush_req) begin
        m_busy = 1; m_ptr = 0;
      end else if (req_valid) begin
        s = int'(req_addr[11:4]); t = req_addr[31:12]; hw = -1;
        for (int i = 0; i < 4; i++) if (m_v[i][s] && m_tag[i][s] == t) hw = i;
        if (hw >= 0) begin
          e_hit = 1; e_way = 2'(hw); touch(s, hw);
          if (req_write) begin
            if (mode_wb && !req_lock) begin
              if (req_be != 0) m_d[hw][s][req_addr[3:2]] = 1;
            end else begin
              e_bw = 1; e_bw_addr = req_addr; e_bw_be = req_be;
            end
          end
        end else begin
          e_miss = 1;
          if (req_write) begin
            e_bw = 1; e_bw_addr = req_addr; e_bw_be = req_be;
          end else if (!mode_cd) begin
            v = pick_victim(s);
            if (m_v[v][s] && m_d[v][s] != 0) begin
              e_wb = 1; e_wb_addr = {m_tag[v][s], s[7:0], 4'h0}; e_wb_mask = m_d[v][s];
            end
            e_fill = 1; e_fill_addr = {req_addr[31:4], 4'h0}; e_way = 2'(v);
            m_tag[v][s] = t; m_v[v][s] = 1; m_d[v][s] = 0;
            touch(s, v);
          end
        end
      end
    end
    e_busy = m_busy;
  end

  // ---------------- comparison ----------------
  task automatic chk(string rq, string nm, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", rq, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running && rst_n) begin
      chk("R9", "busy", 32'(busy), 32'(e_busy));
      chk("R2", "rsp_hit", 32'(rsp_hit), 32'(e_hit));
      chk("R2", "rsp_miss", 32'(rsp_miss), 32'(e_miss));
      chk("R3 R4", "rsp_way", 32'(rsp_way), 32'(e_way));
      chk("R3 R8", "fill_req", 32'(fill_req), 32'(e_fill));
      chk("R3", "fill_addr", fill_addr, e_fill_addr);
      chk("R7 R9", "wb_req", 32'(wb_req), 32'(e_wb));
      chk("R7", "wb_addr", wb_addr, e_wb_addr);
      chk("R5 R7", "wb_mask", 32'(wb_mask), 32'(e_wb_mask));
      chk("R6", "bus_wr_req", 32'(bus_wr_req), 32'(e_bw));
      chk("R6", "bus_wr_addr", bus_wr_addr, e_bw_addr);
      chk("R6", "bus_wr_be", 32'(bus_wr_be), 32'(e_bw_be));
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [31:0] mk(int tg, int st, int dw);
    return {20'(tg), 8'(st), 2'(dw), 2'b00};
  endfunction

  task automatic idle(int n);
    req_valid = 0; req_write = 0; req_lock = 0; flush_req = 0; req_be = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [31:0] a);
    req_valid = 1; req_write = 0; req_lock = 0; req_addr = a; req_be = 4'hF;
    @(negedge clk);
    idle(1);
  endtask

  task automatic wr(logic [31:0] a, logic [3:0] be, logic lk);
    req_valid = 1; req_write = 1; req_lock = lk; req_addr = a; req_be = be;
    @(negedge clk);
    idle(1);
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_lock = 0; req_addr = 0;
    req_be = 0; mode_cd = 0; mode_wb = 1; flush_req = 0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1", "reset outputs",
        {busy, rsp_hit, rsp_miss, fill_req, wb_req, bus_wr_req, rsp_way, wb_mask, bus_wr_be},
        32'h0);
    rst_n = 1;
    running = 1;
    idle(2);

    // R3: fill four ways of set 5 in index order
    for (int k = 1; k <= 4; k++) rd(mk(k, 5, 0));
    rd(mk(2, 5, 1));                     // R2 hit
    // R5: dirty every way, plus a zero-byte-enable write
    for (int k = 1; k <= 4; k++) wr(mk(k, 5, k % 4), 4'h3, 0);
    wr(mk(3, 5, 2), 4'h0, 0);
    rd(mk(9, 5, 0));                     // R7 dirty victim evicted with fill
    rd(mk(10, 5, 0));                    // R4 next PLRU victim
    // R6: write-through and locked writes, write miss
    mode_wb = 0; wr(mk(9, 5, 1), 4'hC, 0); mode_wb = 1;
    wr(mk(10, 5, 3), 4'h1, 1);
    wr(mk(77, 6, 0), 4'hF, 0);
    rd(mk(77, 6, 0));
    // R8: cache disabled
    mode_cd = 1;
    rd(mk(50, 7, 0));
    rd(mk(50, 7, 0));
    rd(mk(9, 5, 0));
    wr(mk(10, 5, 0), 4'h8, 0);
    mode_cd = 0;
    // R9: flush with a request in the same cycle, requests while busy
    req_valid = 1; req_write = 0; req_addr = mk(9, 5, 0); flush_req = 1;
    @(negedge clk);
    idle(0);
    for (int k = 0; k < 20; k++) begin
      req_valid = 1; req_addr = mk(k, 5, 0); @(negedge clk);
    end
    idle(1100);
    rd(mk(9, 5, 0));
    rd(mk(9, 5, 0));

    // random traffic
    for (int i = 0; i < 6000; i++) begin
      req_valid = ($urandom % 3) != 0;
      req_write = $urandom % 2;
      req_lock  = ($urandom % 8) == 0;
      req_be    = 4'($urandom);
      req_addr  = {20'($urandom % 6), 8'($urandom % 3), 4'($urandom)};
      flush_req = ($urandom % 3000) == 0;
      if (($urandom % 64) == 0) mode_wb = ~mode_wb;
      mode_cd = ($urandom % 10) == 0;
      @(negedge clk);
    end
    mode_cd = 0; mode_wb = 1;
    idle(1100);
    report();
  end
endmodule